// File: doc/BRIEF.md
# CPU Idle State Controller

This block manages the low-power wait state of a small 8-bit processor core. When the instruction decoder reports an idle instruction, the controller releases the data bus and forces both memory strobes to their inactive (high) level. On the next low-to-high transition of the timing pulse TPB, it raises a freeze control that makes every other external output of the core hold its value. The sequencer keeps repeating its execute cycle until this block lets it go.

Idle ends only when an I/O service request is accepted. The request can be DMA-in, DMA-out or a qualified interrupt. The request inputs are registered on the internal clock, which keeps running while the timing pulses are stopped. The controller picks one request, sends a one-cycle acknowledge for it to the request arbiter, and sends a one-cycle resume pulse to the sequencer in the same cycle. The bus controls are released in that cycle. The pins carry single-bit control levels and pulses only, so there is no valid/ready handshake.

Top module: `idle_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `freeze_o` and `strobe_hold_o` are 0, `data_oe_o` is 1, and all three acknowledges and `resume_o` are 0.
- R2: A cycle with `idle_dec_i` high while running makes `strobe_hold_o` 1 and `data_oe_o` 0 from the next clock edge onward. `freeze_o` stays 0.
- R3: In idle, `freeze_o` goes to 1 on the clock edge that samples `tpb_i` high when the edge before it sampled `tpb_i` low. If TPB is already high when idle starts, it has no effect until it has been seen low and then high again.
- R4: A request that is present at one clock edge gives its acknowledge after the following edge (with one synchronizer stage). The acknowledge and `resume_o` are high for exactly one cycle. In that same cycle, `freeze_o` and `strobe_hold_o` return to 0 and `data_oe_o` returns to 1.
- R5: Priority is DMA-in first, then DMA-out, then interrupt. At most one acknowledge is high in any cycle.
- R6: An interrupt wakes the core only when `mie_i` is 1 and at least one of these holds: `cie_i` is 1 with `ctr_irq_i` pending, or `xie_i` is 1 with `ext_irq_i` pending. An unqualified interrupt leaves `freeze_o` at 1 and gives no acknowledge.
- R7: While running (not idle), requests give no acknowledge and no `resume_o`.
- R8: A synchronous reset during idle returns every output to its R1 values at the next edge, and no acknowledge is raised.
- R9: In idle, if a wake request and a TPB rise reach the same clock edge, the wake takes effect and `freeze_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, running during idle |
| rst | input | 1 | Synchronous reset, active high |
| idle_dec_i | input | 1 | Idle instruction decoded (one-cycle strobe) |
| tpb_i | input | 1 | Timing pulse B, synchronous to clk |
| dma_in_req_i | input | 1 | DMA-in service request |
| dma_out_req_i | input | 1 | DMA-out service request |
| ctr_irq_i | input | 1 | Counter interrupt pending |
| ext_irq_i | input | 1 | External interrupt pending |
| mie_i | input | 1 | Master interrupt enable |
| cie_i | input | 1 | Counter interrupt enable |
| xie_i | input | 1 | External interrupt enable |
| freeze_o | output | 1 | Hold all general outputs at their current value |
| strobe_hold_o | output | 1 | Force memory read and write strobes high |
| data_oe_o | output | 1 | Data bus output enable (0 = released) |
| ack_dma_in_o | output | 1 | DMA-in acknowledge pulse |
| ack_dma_out_o | output | 1 | DMA-out acknowledge pulse |
| ack_irq_o | output | 1 | Interrupt acknowledge pulse |
| resume_o | output | 1 | Resume pulse to the sequencer |

## Verification
If the block holds a wrong idle state, the mismatch appears on `strobe_hold_o`, `data_oe_o` or `freeze_o` one edge after the decode strobe, the TPB rise or the reset that should have moved it. A wrong priority or enable qualification appears on the acknowledge pins exactly two edges after the request is driven. A lost or repeated wake appears either as an acknowledge that stays high past one cycle or as a freeze that never clears. Every check is therefore sampled at a fixed number of edges after the stimulus.

// File: rtl/idle_ctrl_pkg.sv
package idle_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FROZEN = 2'd2
  } idle_state_e;

  localparam int SRC_W    = 4;
  localparam int SRC_DIN  = 0;
  localparam int SRC_DOUT = 1;
  localparam int SRC_CTR  = 2;
  localparam int SRC_EXT  = 3;

  localparam int ACK_W    = 3;
  localparam int ACK_DIN  = 0;
  localparam int ACK_DOUT = 1;
  localparam int ACK_IRQ  = 2;
endpackage

// File: rtl/idle_req_sync.sv
module idle_req_sync #(
  parameter int W      = 4,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/idle_wake_arb.sv
module idle_wake_arb
  import idle_ctrl_pkg::*;
(
  input  logic [SRC_W-1:0] req_i,
  input  logic             mie_i,
  input  logic             cie_i,
  input  logic             xie_i,
  output logic [ACK_W-1:0] grant_o,
  output logic             wake_o
);
  logic irq_ok;

  always_comb begin
    irq_ok  = mie_i & ((cie_i & req_i[SRC_CTR]) | (xie_i & req_i[SRC_EXT]));
    grant_o = '0;
    if (req_i[SRC_DIN])       grant_o[ACK_DIN]  = 1'b1;
    else if (req_i[SRC_DOUT]) grant_o[ACK_DOUT] = 1'b1;
    else if (irq_ok)          grant_o[ACK_IRQ]  = 1'b1;
    wake_o = |grant_o;
  end

  // R5
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_dec_i,
  input  logic             tpb_i,
  input  logic [ACK_W-1:0] grant_i,
  input  logic             wake_i,
  output logic             freeze_o,
  output logic             strobe_hold_o,
  output logic             data_oe_o,
  output logic [ACK_W-1:0] ack_o,
  output logic             resume_o
);
  idle_state_e state_q, state_d;
  logic        tpb_q;
  logic        tpb_rise;
  logic        in_idle;
  logic [ACK_W-1:0] ack_q, ack_d;
  logic        resume_q, resume_d;

  assign tpb_rise = tpb_i & ~tpb_q;
  assign in_idle  = (state_q != ST_RUN);

  always_comb begin
    state_d  = state_q;
    ack_d    = '0;
    resume_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (idle_dec_i) state_d = ST_ARMED;
      end
      ST_ARMED, ST_FROZEN: begin
        if (wake_i) begin
          state_d  = ST_RUN;
          ack_d    = grant_i;
          resume_d = 1'b1;
        end else if (state_q == ST_ARMED && tpb_rise) begin
          state_d = ST_FROZEN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      tpb_q    <= 1'b0;
      ack_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      tpb_q    <= tpb_i;
      ack_q    <= ack_d;
      resume_q <= resume_d;
    end
  end

  assign freeze_o      = (state_q == ST_FROZEN);
  assign strobe_hold_o = in_idle;
  assign data_oe_o     = ~in_idle;
  assign ack_o         = ack_q;
  assign resume_o      = resume_q;

  // R7
  ack_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> $past(in_idle));

  // R3
  freeze_on_tpb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_o) |-> $past(tpb_rise));

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && idle_dec_i) |=> (strobe_hold_o && !freeze_o));

  // R8
  reset_exit_chk: assert property (@(posedge clk)
    rst |=> (!in_idle && ack_o == '0 && !resume_o));

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |=> (ack_o == '0 && !resume_o));
endmodule

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import idle_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_dec_i,
  input  logic tpb_i,
  input  logic dma_in_req_i,
  input  logic dma_out_req_i,
  input  logic ctr_irq_i,
  input  logic ext_irq_i,
  input  logic mie_i,
  input  logic cie_i,
  input  logic xie_i,
  output logic freeze_o,
  output logic strobe_hold_o,
  output logic data_oe_o,
  output logic ack_dma_in_o,
  output logic ack_dma_out_o,
  output logic ack_irq_o,
  output logic resume_o
);
  logic [SRC_W-1:0] req_raw, req_sync;
  logic [ACK_W-1:0] grant, ack;
  logic             wake;

  always_comb begin
    req_raw           = '0;
    req_raw[SRC_DIN]  = dma_in_req_i;
    req_raw[SRC_DOUT] = dma_out_req_i;
    req_raw[SRC_CTR]  = ctr_irq_i;
    req_raw[SRC_EXT]  = ext_irq_i;
  end

  idle_req_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (req_raw),
    .q_o (req_sync)
  );

  idle_wake_arb u_arb (
    .req_i   (req_sync),
    .mie_i   (mie_i),
    .cie_i   (cie_i),
    .xie_i   (xie_i),
    .grant_o (grant),
    .wake_o  (wake)
  );

  idle_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .idle_dec_i    (idle_dec_i),
    .tpb_i         (tpb_i),
    .grant_i       (grant),
    .wake_i        (wake),
    .freeze_o      (freeze_o),
    .strobe_hold_o (strobe_hold_o),
    .data_oe_o     (data_oe_o),
    .ack_o         (ack),
    .resume_o      (resume_o)
  );

  assign ack_dma_in_o  = ack[ACK_DIN];
  assign ack_dma_out_o = ack[ACK_DOUT];
  assign ack_irq_o     = ack[ACK_IRQ];

  // R5
  dma_first_chk: assert property (@(posedge clk) disable iff (rst)
    ack_irq_o |-> !$past(req_sync[SRC_DIN] | req_sync[SRC_DOUT]));
endmodule

// File: tb/idle_ctrl_tb.sv
module idle_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_dec = 0, tpb = 0, din = 0, dout = 0, ctr = 0, ext = 0;
  logic mie = 0, cie = 0, xie = 0;
  logic freeze, shold, doe, a_din, a_dout, a_irq, resume;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  idle_ctrl dut_i (
    .clk(clk), .rst(rst), .idle_dec_i(idle_dec), .tpb_i(tpb),
    .dma_in_req_i(din), .dma_out_req_i(dout), .ctr_irq_i(ctr), .ext_irq_i(ext),
    .mie_i(mie), .cie_i(cie), .xie_i(xie),
    .freeze_o(freeze), .strobe_hold_o(shold), .data_oe_o(doe),
    .ack_dma_in_o(a_din), .ack_dma_out_o(a_dout), .ack_irq_o(a_irq),
    .resume_o(resume)
  );

  // vector: [9:3] = {din,dout,ctr,ext,mie,cie,xie}, [2:0] = expected {irq,dout,din}
  localparam logic [9:0] VEC [12] = '{
    10'b1000000_001, 10'b0100000_010, 10'b1100000_001, 10'b0010110_100,
    10'b0001101_100, 10'b0010101_000, 10'b0010010_000, 10'b0001110_000,
    10'b0110110_010, 10'b1111111_001, 10'b0000111_000, 10'b0011011_000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; idle_dec = 0; tpb = 0;
    {din, dout, ctr, ext, mie, cie, xie} = '0;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic enter_idle();
    idle_dec = 1'b1; cyc(1); idle_dec = 1'b0;
  endtask

  task automatic pulse_tpb();
    tpb = 1'b1; cyc(1); tpb = 1'b0; cyc(1);
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, freeze, shold, doe, a_irq, a_dout, a_din, resume};
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(1);
    // R1: reset state, during and just after reset
    chk("R1 in reset", outs(), 8'b0_0_0_1_000_0);
    rst = 1'b0; cyc(1);
    chk("R1 after reset", outs(), 8'b0_0_0_1_000_0);

    // table walk: R4 R5 R6
    foreach (VEC[k]) begin
      do_reset();
      enter_idle();
      pulse_tpb();
      chk("R3 frozen before request", {7'b0, freeze}, 8'd1);
      {din, dout, ctr, ext, mie, cie, xie} = VEC[k][9:3];
      cyc(2);
      if (VEC[k][2:0] != 3'b000) begin
        chk("R4 R5 R6 ack", {4'b0, a_irq, a_dout, a_din, resume}, {4'b0, VEC[k][2:0], 1'b1});
        chk("R4 bus released", {5'b0, freeze, shold, doe}, 8'b001);
        {din, dout, ctr, ext} = '0;
        cyc(1);
        chk("R4 single pulse", {4'b0, a_irq, a_dout, a_din, resume}, 8'd0);
      end else begin
        chk("R6 unqualified stays frozen", {4'b0, freeze, a_irq, a_dout, a_din}, 8'b1000);
      end
    end

    // R2: decode enters idle, no freeze yet
    do_reset();
    enter_idle();
    chk("R2 armed", {5'b0, freeze, shold, doe}, 8'b010);

    // R3: TPB already high at entry does not freeze
    do_reset();
    tpb = 1'b1; cyc(1);
    enter_idle(); cyc(2);
    chk("R3 held TPB no freeze", {7'b0, freeze}, 8'd0);
    tpb = 1'b0; cyc(1);
    tpb = 1'b1; cyc(1);
    chk("R3 fresh rise freezes", {7'b0, freeze}, 8'd1);
    tpb = 1'b0;

    // R7: requests while running are not acknowledged
    do_reset();
    din = 1; dout = 1; ctr = 1; mie = 1; cie = 1;
    cyc(3);
    chk("R7 running no ack", {4'b0, a_irq, a_dout, a_din, resume}, 8'd0);

    // R8: reset during idle clears everything, no ack
    do_reset();
    enter_idle(); pulse_tpb();
    din = 1; rst = 1'b1; cyc(1);
    chk("R8 reset exits idle", outs(), 8'b0_0_0_1_000_0);
    cyc(1);
    chk("R8 no ack after reset", outs(), 8'b0_0_0_1_000_0);

    // R9: wake and TPB rise at the same edge
    do_reset();
    enter_idle();
    dout = 1; cyc(1);
    tpb = 1'b1; cyc(1);
    chk("R9 wake wins", {4'b0, freeze, a_dout, resume, shold}, 8'b0110);
    dout = 0; tpb = 0; cyc(1);
    chk("R9 no late freeze", {7'b0, freeze}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule